// File: doc/BRIEF.md
# Two-Port Frame Relay with Destination Filtering

This block sits between the receive and transmit byte streams of two Ethernet MACs. Every frame that arrives on one port is copied unchanged to that port's local receive outputs. At the same time it is written into a relay FIFO that feeds the opposite port's transmit stream. After the sixth byte, which completes the destination address, the block decides whether the frame is forwarded. The decision comes from the frame's destination class, a set of per-direction enable bits and, as an option, an external lookup hit. A rejected frame, a runt, or a frame that finds its FIFO full is removed by moving the FIFO write pointer back to the last committed frame boundary. The rest of that frame is ignored.

Each transmit port carries two sources: relayed frames and frames from a local transmit stream. An arbiter grants one of them at each frame boundary. The local stream normally wins. When the relay FIFO fill is above a per-direction threshold, the relay source wins instead, so that a backed-up relay path drains before it overflows. A granted frame always runs to its last byte. Ingress streams cannot be stalled. Egress and local transmit streams use valid/ready with a last marker.

Top module: `eth_relay2`

## Requirements
- R1: The 48-bit destination is the first six frame bytes, with the first byte as bits 47:40. Classes are tested in this order: equal to `station_mac` gives self (0); all ones gives broadcast (1); bit 40 set (bit 0 of the first byte) gives multicast (2); anything else gives other (3).
- R2: A frame entering port d is forwarded only if `relay_on` is 1 and bit c of `fwd_en[d]` is 1, where c is the class code from R1. Any other frame never appears on the egress port.
- R3: When `cam_sel[d]` is 1, multicast and other frames from port d are forwarded only if `cam_hit[d]` is also 1 in the cycle that carries the sixth byte. Self and broadcast frames ignore `cam_hit`.
- R4: A forwarded frame from port d leaves on port 1-d. Its bytes and last marker are unchanged and in the same order. Frames from one port leave in arrival order.
- R5: `lrx_valid`, `lrx_data` and `lrx_last` of each port follow that port's receive inputs in the same cycle, whatever the relay decision.
- R6: A frame with fewer than six bytes is never forwarded.
- R7: If a byte arrives when the FIFO holds DEPTH entries, the whole frame is dropped and `ovf_count[d]` rises by exactly one. Frames committed earlier are still delivered intact.
- R8: No byte of a frame is offered on egress before the cycle after its last byte is received.
- R9: At a frame boundary, if relay FIFO fill (every byte written and not yet read) is at most `prio_thresh[d]`, a waiting local frame is granted first. If the fill is strictly above the threshold, the relay frame is granted first.
- R10: Once the first byte of a frame has been accepted on egress, no byte from the other source is accepted until that frame's last byte.
- R11: A dropped or rolled-back frame leaves no bytes behind. The next frame through the same FIFO arrives complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rx_valid | input | 2 | Receive byte valid, one bit per port |
| rx_data | input | 2x8 | Receive byte per port |
| rx_last | input | 2 | Last byte of the received frame |
| cam_hit | input | 2 | External lookup hit per ingress port |
| station_mac | input | 48 | Shared station address |
| relay_on | input | 1 | Global relay enable |
| fwd_en | input | 2x4 | Per-ingress-port class enables, bit index = class code |
| cam_sel | input | 2 | Apply `cam_hit` to multicast and other classes |
| prio_thresh | input | 2x(log2(DEPTH)+1) | Fill threshold per direction, indexed by ingress port |
| lrx_valid | output | 2 | Local receive valid |
| lrx_data | output | 2x8 | Local receive byte |
| lrx_last | output | 2 | Local receive last |
| ltx_valid | input | 2 | Local transmit valid, per egress port |
| ltx_data | input | 2x8 | Local transmit byte |
| ltx_last | input | 2 | Local transmit last |
| ltx_ready | output | 2 | Local transmit byte accepted |
| tx_valid | output | 2 | Egress valid |
| tx_data | output | 2x8 | Egress byte |
| tx_last | output | 2 | Egress last |
| tx_ready | input | 2 | Egress ready |
| ovf_count | output | 2xOVF_W | Frames lost to a full FIFO, per ingress port |

## Verification
The two hardest conditions to reach are a full relay FIFO in the middle of a frame, and a threshold comparison that lands exactly on equality at a frame boundary. Neither occurs while the egress port drains freely. The stimulus therefore holds egress ready low and stacks fixed-length broadcast frames until the fill reaches a known value. It then offers a local frame or one more relay frame, and releases ready in the same cycle that the local source becomes valid. The order of frames on egress then shows which side of the threshold the arbiter used, and the overflow counter shows whether the rollback happened.

// File: rtl/frelay_pkg.sv
`timescale 1ns/1ps
package frelay_pkg;

   typedef enum logic [1:0] {
      DC_SELF  = 2'd0,
      DC_BCAST = 2'd1,
      DC_MCAST = 2'd2,
      DC_OTHER = 2'd3
   } dst_class_e;

   typedef enum logic [1:0] {
      OWN_NONE  = 2'd0,
      OWN_RELAY = 2'd1,
      OWN_LOCAL = 2'd2
   } owner_e;

   localparam int unsigned DA_BYTES = 6;

   function automatic dst_class_e classify(input logic [47:0] da, input logic [47:0] mac);
      if (da == mac)        return DC_SELF;
      else if (&da)         return DC_BCAST;
      else if (da[40])      return DC_MCAST;
      else                  return DC_OTHER;
   endfunction

endpackage

// File: rtl/frelay_fifo.sv
`timescale 1ns/1ps
module frelay_fifo #(
   parameter int unsigned DEPTH = 2048,
   parameter int unsigned W     = 9
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic [W-1:0]                wr_data,
   input  logic                        commit,
   input  logic                        rollback,
   output logic                        room,
   output logic                        rd_valid,
   output logic [W-1:0]                rd_data,
   input  logic                        rd_en,
   output logic [$clog2(DEPTH):0]      fill
);
   localparam int unsigned AW = $clog2(DEPTH);
   localparam int unsigned PW = AW + 1;

   if (DEPTH < 8 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("frelay_fifo: DEPTH must be a power of two of at least 8");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wr_ptr, cmt_ptr, rd_ptr;

   assign fill     = wr_ptr - rd_ptr;
   assign room     = (fill != PW'(DEPTH));
   assign rd_valid = (cmt_ptr != rd_ptr);
   assign rd_data  = mem[rd_ptr[AW-1:0]];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_ptr[AW-1:0]] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr  <= '0;
         cmt_ptr <= '0;
         rd_ptr  <= '0;
      end else begin
         if (rollback)   wr_ptr <= cmt_ptr;
         else if (wr_en) wr_ptr <= wr_ptr + 1'b1;
         if (commit && wr_en) cmt_ptr <= wr_ptr + 1'b1;
         if (rd_en && rd_valid) rd_ptr <= rd_ptr + 1'b1;
      end
   end

   assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> room);

endmodule

// File: rtl/frelay_ingress.sv
`timescale 1ns/1ps
module frelay_ingress
   import frelay_pkg::*;
#(
   parameter int unsigned OVF_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [7:0]       in_data,
   input  logic             in_last,
   input  logic [47:0]      station_mac,
   input  logic             relay_on,
   input  logic [3:0]       fwd_en,
   input  logic             cam_sel,
   input  logic             cam_hit,
   input  logic             room,
   output logic             wr_en,
   output logic [8:0]       wr_data,
   output logic             commit,
   output logic             rollback,
   output logic [OVF_W-1:0] ovf_count
);
   localparam logic [2:0] DEC_IDX = 3'(DA_BYTES - 1);
   localparam logic [2:0] PAST_DA = 3'(DA_BYTES);

   if (OVF_W < 1) begin : g_bad_w
      $error("frelay_ingress: OVF_W must be positive");
   end

   logic [2:0]  cnt;
   logic        dropping;
   logic [39:0] da_hi;
   dst_class_e  cls;
   logic        cam_ok, relay_ok, keep, active, no_room, filt, runt;

   always_comb begin
      cls      = classify({da_hi, in_data}, station_mac);
      cam_ok   = !(cam_sel && (cls == DC_MCAST || cls == DC_OTHER)) || cam_hit;
      relay_ok = relay_on && fwd_en[cls] && cam_ok;
      keep     = (cnt == DEC_IDX) ? relay_ok : 1'b1;
      active   = in_valid && !dropping;
      no_room  = active && !room;
      filt     = active && room && !keep;
      runt     = active && room && keep && in_last && (cnt < DEC_IDX);
   end

   assign wr_en    = active && room && keep && !runt;
   assign wr_data  = {in_last, in_data};
   assign commit   = wr_en && in_last;
   assign rollback = no_room || filt || runt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt       <= '0;
         dropping  <= 1'b0;
         da_hi     <= '0;
         ovf_count <= '0;
      end else if (in_valid) begin
         if (dropping) begin
            if (in_last) dropping <= 1'b0;
         end else begin
            if (cnt < DEC_IDX) da_hi <= {da_hi[31:0], in_data};
            if (rollback) begin
               dropping <= !in_last;
               cnt      <= '0;
            end else if (in_last) begin
               cnt <= '0;
            end else if (cnt != PAST_DA) begin
               cnt <= cnt + 1'b1;
            end
            if (no_room) ovf_count <= ovf_count + 1'b1;
         end
      end
   end

   assert_ovf_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_count != $past(ovf_count)) |-> $past(in_valid && !room));

   assert_no_runt_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> (cnt >= DEC_IDX));

endmodule

// File: rtl/frelay_egress.sv
`timescale 1ns/1ps
module frelay_egress
   import frelay_pkg::*;
#(
   parameter int unsigned PW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rq_valid,
   input  logic [8:0]    rq_data,
   output logic          rq_ready,
   input  logic [PW-1:0] fill,
   input  logic [PW-1:0] thresh,
   input  logic          lt_valid,
   input  logic [7:0]    lt_data,
   input  logic          lt_last,
   output logic          lt_ready,
   output logic          eg_valid,
   output logic [7:0]    eg_data,
   output logic          eg_last,
   input  logic          eg_ready
);
   owner_e owner, sel;
   logic   fire;

   always_comb begin
      if (owner != OWN_NONE)              sel = owner;
      else if (rq_valid && fill > thresh) sel = OWN_RELAY;
      else if (lt_valid)                  sel = OWN_LOCAL;
      else if (rq_valid)                  sel = OWN_RELAY;
      else                                sel = OWN_NONE;

      unique case (sel)
         OWN_RELAY: begin eg_valid = rq_valid; eg_data = rq_data[7:0]; eg_last = rq_data[8]; end
         OWN_LOCAL: begin eg_valid = lt_valid; eg_data = lt_data;      eg_last = lt_last;    end
         default:   begin eg_valid = 1'b0;     eg_data = '0;           eg_last = 1'b0;       end
      endcase
   end

   assign rq_ready = (sel == OWN_RELAY) && eg_ready;
   assign lt_ready = (sel == OWN_LOCAL) && eg_ready;
   assign fire     = eg_valid && eg_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    owner <= OWN_NONE;
      else if (fire) owner <= eg_last ? OWN_NONE : sel;
   end

   assert_one_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rq_ready, lt_ready}));

   assert_relay_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !eg_last && rq_ready) |=> !lt_ready);

   assert_local_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !eg_last && lt_ready) |=> !rq_ready);

endmodule

// File: rtl/eth_relay2.sv
`timescale 1ns/1ps
module eth_relay2
   import frelay_pkg::*;
#(
   parameter int unsigned DEPTH = 2048,
   parameter int unsigned OVF_W = 16
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic [1:0]                          rx_valid,
   input  logic [1:0][7:0]                     rx_data,
   input  logic [1:0]                          rx_last,
   input  logic [1:0]                          cam_hit,
   input  logic [47:0]                         station_mac,
   input  logic                                relay_on,
   input  logic [1:0][3:0]                     fwd_en,
   input  logic [1:0]                          cam_sel,
   input  logic [1:0][$clog2(DEPTH):0]         prio_thresh,
   output logic [1:0]                          lrx_valid,
   output logic [1:0][7:0]                     lrx_data,
   output logic [1:0]                          lrx_last,
   input  logic [1:0]                          ltx_valid,
   input  logic [1:0][7:0]                     ltx_data,
   input  logic [1:0]                          ltx_last,
   output logic [1:0]                          ltx_ready,
   output logic [1:0]                          tx_valid,
   output logic [1:0][7:0]                     tx_data,
   output logic [1:0]                          tx_last,
   input  logic [1:0]                          tx_ready,
   output logic [1:0][OVF_W-1:0]               ovf_count
);
   localparam int unsigned PW = $clog2(DEPTH) + 1;

   assign lrx_valid = rx_valid;
   assign lrx_data  = rx_data;
   assign lrx_last  = rx_last;

   for (genvar d = 0; d < 2; d++) begin : g_dir
      localparam int E = 1 - d;

      logic          wr_en, commit, rollback, room, rd_valid, rd_en;
      logic [8:0]    wr_data, rd_data;
      logic [PW-1:0] fill;

      frelay_ingress #(.OVF_W(OVF_W)) i_ingress (
         .clk        (clk),
         .rst_n      (rst_n),
         .in_valid   (rx_valid[d]),
         .in_data    (rx_data[d]),
         .in_last    (rx_last[d]),
         .station_mac(station_mac),
         .relay_on   (relay_on),
         .fwd_en     (fwd_en[d]),
         .cam_sel    (cam_sel[d]),
         .cam_hit    (cam_hit[d]),
         .room       (room),
         .wr_en      (wr_en),
         .wr_data    (wr_data),
         .commit     (commit),
         .rollback   (rollback),
         .ovf_count  (ovf_count[d])
      );

      frelay_fifo #(.DEPTH(DEPTH), .W(9)) i_fifo (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (wr_en),
         .wr_data (wr_data),
         .commit  (commit),
         .rollback(rollback),
         .room    (room),
         .rd_valid(rd_valid),
         .rd_data (rd_data),
         .rd_en   (rd_en),
         .fill    (fill)
      );

      frelay_egress #(.PW(PW)) i_egress (
         .clk     (clk),
         .rst_n   (rst_n),
         .rq_valid(rd_valid),
         .rq_data (rd_data),
         .rq_ready(rd_en),
         .fill    (fill),
         .thresh  (prio_thresh[d]),
         .lt_valid(ltx_valid[E]),
         .lt_data (ltx_data[E]),
         .lt_last (ltx_last[E]),
         .lt_ready(ltx_ready[E]),
         .eg_valid(tx_valid[E]),
         .eg_data (tx_data[E]),
         .eg_last (tx_last[E]),
         .eg_ready(tx_ready[E])
      );

      assert_commit_before_egress_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_en && rd_valid) |-> (fill != '0));
   end

endmodule

// File: tb/test_eth_relay2.sv
`timescale 1ns/1ps
module test_eth_relay2;
   localparam int DEPTH = 64;
   localparam int PW    = 7;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic [1:0]          rx_valid = '0, rx_last = '0, cam_hit = '0, cam_sel = '0;
   logic [1:0][7:0]     rx_data = '0;
   logic [47:0]         station_mac = 48'h02_11_22_33_44_55;
   logic                relay_on = 1'b1;
   logic [1:0][3:0]     fwd_en = '1;
   logic [1:0][PW-1:0]  prio_thresh = '0;
   logic [1:0]          lrx_valid, lrx_last, ltx_ready, tx_valid, tx_last;
   logic [1:0][7:0]     lrx_data, tx_data;
   logic [1:0]          ltx_valid = '0, ltx_last = '0, tx_ready = '0;
   logic [1:0][7:0]     ltx_data = '0;
   logic [1:0][15:0]    ovf_count;

   eth_relay2 #(.DEPTH(DEPTH), .OVF_W(16)) i_eth_relay2 (.*);

   int checks = 0, fails = 0;
   logic [8:0] q0[$], q1[$];
   logic [7:0] fbuf [64];
   bit watch_early = 0;
   string cur_req = "R4";

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic bit model_relay(int p, int len, bit hit);
      logic [47:0] da;
      int cls;
      da = {fbuf[0], fbuf[1], fbuf[2], fbuf[3], fbuf[4], fbuf[5]};
      if (len < 6 || !relay_on) return 0;
      if (da == station_mac) cls = 0;
      else if (da == '1)     cls = 1;
      else if (da[40])       cls = 2;
      else                   cls = 3;
      if (cls >= 2 && cam_sel[p] && !hit) return 0;
      return fwd_en[p][cls];
   endfunction

   task automatic push_exp(int e, int len);
      for (int i = 0; i < len; i++) begin
         if (e == 0) q0.push_back({(i == len - 1), fbuf[i]});
         else        q1.push_back({(i == len - 1), fbuf[i]});
      end
   endtask

   task automatic push_local(int e, int len, logic [7:0] base);
      for (int i = 0; i < len; i++) begin
         if (e == 0) q0.push_back({(i == len - 1), base + 8'(i)});
         else        q1.push_back({(i == len - 1), base + 8'(i)});
      end
   endtask

   task automatic make_frame(int kind, int len);
      for (int i = 0; i < 64; i++) fbuf[i] = 8'($urandom);
      case (kind)
         0: for (int i = 0; i < 6; i++) fbuf[i] = station_mac[47-8*i -: 8];
         1: for (int i = 0; i < 6; i++) fbuf[i] = 8'hFF;
         2: fbuf[0][0] = 1'b1;
         3: fbuf[0][0] = 1'b0;
         default: begin
            for (int i = 0; i < 6; i++) fbuf[i] = station_mac[47-8*i -: 8];
            fbuf[5] = fbuf[5] ^ 8'h01;
         end
      endcase
      if (len < 0) fbuf[0] = fbuf[0];
   endtask

   task automatic send_frame(int p, int len, bit hit);
      for (int i = 0; i < len; i++) begin
         @(posedge clk); #1;
         rx_valid[p] = 1'b1;
         rx_data[p]  = fbuf[i];
         rx_last[p]  = (i == len - 1);
         cam_hit[p]  = hit;
      end
      @(posedge clk); #1;
      rx_valid[p] = 1'b0;
      rx_last[p]  = 1'b0;
   endtask

   task automatic send_local(int e, int len, logic [7:0] base);
      for (int i = 0; i < len; i++) begin
         @(posedge clk); #1;
         ltx_valid[e] = 1'b1;
         ltx_data[e]  = base + 8'(i);
         ltx_last[e]  = (i == len - 1);
         do @(negedge clk); while (!ltx_ready[e]);
      end
      @(posedge clk); #1;
      ltx_valid[e] = 1'b0;
      ltx_last[e]  = 1'b0;
   endtask

   // egress and local-receive monitor, sampled at the falling edge
   always @(negedge clk) begin
      if (rst_n) begin
         for (int e = 0; e < 2; e++) begin
            if (rx_valid[e])
               chk({lrx_valid[e], lrx_data[e], lrx_last[e]} == {1'b1, rx_data[e], rx_last[e]},
                   "R5 local receive mirror", {lrx_data[e], lrx_last[e]}, {rx_data[e], rx_last[e]});
            if (tx_valid[e] && tx_ready[e]) begin
               logic [8:0] exp;
               bit have;
               have = (e == 0) ? (q0.size() != 0) : (q1.size() != 0);
               if (!have) chk(0, {cur_req, " unexpected egress byte"}, {tx_last[e], tx_data[e]}, 0);
               else begin
                  exp = (e == 0) ? q0.pop_front() : q1.pop_front();
                  chk({tx_last[e], tx_data[e]} == exp, cur_req, {tx_last[e], tx_data[e]}, exp);
               end
            end
         end
         if (watch_early) chk(tx_valid[1] == 1'b0, "R8 egress before commit", tx_valid[1], 0);
      end
   end

   task automatic drain_and_check(string req);
      repeat (120) @(posedge clk);
      chk(q0.size() == 0 && q1.size() == 0, {req, " all expected frames delivered"},
          q0.size() + q1.size(), 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk(tx_valid == 2'b00, "R8 reset egress idle", tx_valid, 0);
      chk(ovf_count == '0, "R7 reset overflow count", ovf_count, 0);

      // R8: directed commit timing, egress open
      tx_ready = 2'b11;
      cur_req = "R8";
      make_frame(1, 10);
      push_exp(1, 10);
      watch_early = 1;
      send_frame(0, 10, 0);
      watch_early = 0;
      @(negedge clk);
      chk(tx_valid[1] == 1'b1, "R8 egress after last byte", tx_valid[1], 1);
      drain_and_check("R8");

      // R6 directed runt, then R11 follow-up frame
      cur_req = "R6 R11";
      make_frame(1, 4);
      send_frame(0, 4, 0);
      make_frame(0, 12);
      push_exp(1, 12);
      send_frame(0, 12, 0);
      drain_and_check("R6");

      // constrained random filtering across both directions
      cur_req = "R1 R2 R3 R4";
      for (int n = 0; n < 80; n++) begin
         int p, kind, len;
         bit hit;
         p    = $urandom % 2;
         kind = $urandom % 5;
         len  = ($urandom % 10 == 0) ? 1 + $urandom % 5 : 6 + $urandom % 15;
         hit  = $urandom % 2;
         @(posedge clk); #1;
         fwd_en[p]  = 4'($urandom);
         cam_sel[p] = $urandom % 2;
         relay_on   = ($urandom % 10) != 0;
         make_frame(kind, len);
         if (model_relay(p, len, hit)) push_exp(1 - p, len);
         send_frame(p, len, hit);
         repeat ($urandom % 3) @(posedge clk);
      end
      drain_and_check("R2");
      relay_on = 1'b1;
      fwd_en   = '1;
      cam_sel  = '0;

      // R9 relay priority above threshold: fill 30 > 20
      cur_req = "R9 R10 relay-first";
      tx_ready[1] = 1'b0;
      prio_thresh[0] = PW'(20);
      make_frame(1, 10); push_exp(1, 10); send_frame(0, 10, 0);
      push_local(1, 8, 8'hA0);
      make_frame(1, 10); push_exp(1, 10); send_frame(0, 10, 0);
      make_frame(1, 10); push_exp(1, 10); send_frame(0, 10, 0);
      fork
         send_local(1, 8, 8'hA0);
         begin @(posedge clk); #1 tx_ready[1] = 1'b1; end
      join
      drain_and_check("R9");

      // R9 local priority at or below threshold: fill 30 <= 40
      cur_req = "R9 R10 local-first";
      tx_ready[1] = 1'b0;
      prio_thresh[0] = PW'(40);
      push_local(1, 8, 8'hC0);
      for (int k = 0; k < 3; k++) begin
         make_frame(1, 10); push_exp(1, 10); send_frame(0, 10, 0);
      end
      fork
         send_local(1, 8, 8'hC0);
         begin @(posedge clk); #1 tx_ready[1] = 1'b1; end
      join
      drain_and_check("R9");

      // R9 equality boundary: fill 30 == 30 keeps local first
      cur_req = "R9 equal";
      tx_ready[1] = 1'b0;
      prio_thresh[0] = PW'(30);
      push_local(1, 5, 8'hE0);
      for (int k = 0; k < 3; k++) begin
         make_frame(1, 10); push_exp(1, 10); send_frame(0, 10, 0);
      end
      fork
         send_local(1, 5, 8'hE0);
         begin @(posedge clk); #1 tx_ready[1] = 1'b1; end
      join
      drain_and_check("R9");

      // R7 overflow: 60 bytes committed, fourth frame hits a full FIFO
      cur_req = "R7 R11";
      tx_ready[1] = 1'b0;
      prio_thresh[0] = '0;
      for (int k = 0; k < 3; k++) begin
         make_frame(1, 20); push_exp(1, 20); send_frame(0, 20, 0);
      end
      make_frame(1, 20);
      send_frame(0, 20, 0);
      @(negedge clk);
      chk(ovf_count[0] == 16'd1, "R7 overflow count", ovf_count[0], 1);
      chk(ovf_count[1] == 16'd0, "R7 other direction count", ovf_count[1], 0);
      @(posedge clk); #1 tx_ready[1] = 1'b1;
      drain_and_check("R7");
      make_frame(0, 12); push_exp(1, 12); send_frame(0, 12, 0);
      drain_and_check("R11");

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule